// File: doc/BRIEF.md
# Adaptive Peak Level Tracker

This block sits in a receive data path after the sample filter. It follows the positive and the negative peak levels of a signed sample stream centred on a zero bias. From those two levels it forms a decision threshold at their midpoint, so the threshold moves with both the signal amplitude and any DC offset. At each bit strobe it slices the current sample against that threshold to produce one received data bit.

Two control inputs pick how the peak registers adapt. When `acq_i` rises, the block runs a short clamp that pulls both registers toward half the present input. While `acq_i` stays high after that, the registers act as fast peak catchers. With `acq_i` low, `track_i` high selects a slower averaging measurement that is less disturbed by noise. With both low, the registers freeze and decay slowly toward bias, which lets them ride through a fade. Timing comes from two strobes supplied by clock recovery: a mid-bit strobe `half_tick_i` and an end-of-bit strobe `bit_tick_i`.

Each peak register keeps 11 fraction bits below the 12-bit sample scale. The ports show only the integer part, rounded toward minus infinity.

Top module: `peak_level_tracker`

## Requirements
- R1: A 0-to-1 change of `acq_i` puts the block into clamp mode from the next clock. This happens on a clock with no strobe. In clamp, each strobe (half or bit) moves both registers by half the distance toward sample/2. After two such strobes the clamp ends. Clamp is also cancelled at once if `acq_i` drops.
- R2: With `acq_i`=1 after the clamp, every strobe raises the positive register to the sample if the sample is larger. It likewise lowers the negative register to the sample if the sample is smaller.
- R3: With `acq_i`=0 and `track_i`=1, each bit strobe changes each register by a fraction of (sample − register). The fraction is 1/16 when the sample lies beyond the register: above it for the positive register, below it for the negative register. Otherwise the fraction is 1/256, an arithmetic shift. Half strobes change nothing.
- R4: With `acq_i`=0 and `track_i`=0, sample values are ignored. Each bit strobe subtracts register/2048 (arithmetic shift) from each register, so both move toward zero.
- R5: While `acq_i`=1, `track_i` has no effect on the mode or on the register updates.
- R6: `thresh_o` equals floor((`pos_peak_o` + `neg_peak_o`) / 2), computed from the current register values.
- R7: At each bit strobe, `data_o` takes 0 if the sample is above `thresh_o` and 1 otherwise (equality gives 1). It holds that value until the next bit strobe.
- R8: `mode_o` shows the active mode: 2'b00 hold/decay, 2'b01 averaging, 2'b10 fast peak, 2'b11 clamp.
- R9: After synchronous reset both registers, `thresh_o` and `data_o` are zero, and no clamp is pending.

Samples and peak outputs are 12-bit two's complement.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous reset, active low |
| sample_i | input | 12 | Filtered signed receive sample |
| half_tick_i | input | 1 | Mid-bit strobe, one clock wide |
| bit_tick_i | input | 1 | End-of-bit strobe, one clock wide |
| acq_i | input | 1 | Acquire: rising edge starts clamp, high selects fast peak |
| track_i | input | 1 | With acquire low: 1 averaging, 0 hold/decay |
| pos_peak_o | output | 12 | Positive peak level, integer part |
| neg_peak_o | output | 12 | Negative peak level, integer part |
| thresh_o | output | 12 | Decision threshold |
| data_o | output | 1 | Sliced data bit |
| mode_o | output | 2 | Active mode code |

## Verification
Two conditions are hard to reach from the ports. The first is the hold decay, because one bit strobe changes a register only in its fraction bits. The bench stays in hold for hundreds of bit periods while driving full-scale samples that must be ignored. It then compares the visible integer levels against a fractional reference model. The second is the clamp sequencing, which depends on `acq_i` rising on a clock with no strobe. The bench places that edge, then counts exactly two strobes before expecting fast-peak mode. It repeats the sequence from a negative input and toggles `track_i` during fast mode.

// File: rtl/pkt_pkg.sv
// Package: shared types for the peak level tracker.
// Assumes: the mode codes are visible at the top port and keep these values.
package pkt_pkg;
    typedef enum logic [1:0] {
        MD_HOLD  = 2'b00,
        MD_AVG   = 2'b01,
        MD_FAST  = 2'b10,
        MD_CLAMP = 2'b11
    } pkt_mode_e;
endpackage

// File: rtl/pkt_mode_ctrl.sv
// Module: pkt_mode_ctrl
// Decides the adaptation mode from acquire/track and a clamp window counted in strobes.
// Assumes: acquire rises on a clock without a strobe; strobes are one clock wide.
module pkt_mode_ctrl
    import pkt_pkg::*;
#(
    parameter int CLAMP_TICKS = 2
) (
    input  logic      clk,
    input  logic      rst_n,
    input  logic      acq_i,
    input  logic      track_i,
    input  logic      tick_any_i,
    output pkt_mode_e mode_o
);
    localparam int CNT_W = (CLAMP_TICKS > 2) ? $clog2(CLAMP_TICKS) : 1;
    localparam logic [CNT_W-1:0] CNT_LAST = CNT_W'(CLAMP_TICKS - 1);

    logic             acq_q;
    logic             clamp_q;
    logic [CNT_W-1:0] cnt_q;

    // Edge detect on acquire and clamp window counting.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            acq_q   <= 1'b0;
            clamp_q <= 1'b0;
            cnt_q   <= '0;
        end else begin
            acq_q <= acq_i;
            if (acq_i && !acq_q) begin
                clamp_q <= 1'b1;
                cnt_q   <= '0;
            end else if (!acq_i) begin
                clamp_q <= 1'b0;
            end else if (clamp_q && tick_any_i) begin
                if (cnt_q == CNT_LAST) clamp_q <= 1'b0;
                else                   cnt_q   <= cnt_q + 1'b1;
            end
        end
    end

    // Mode select: clamp, then acquire overrides track.
    always_comb begin
        if (clamp_q && acq_i) mode_o = MD_CLAMP;
        else if (acq_i)       mode_o = MD_FAST;
        else if (track_i)     mode_o = MD_AVG;
        else                  mode_o = MD_HOLD;
    end

    AST_CLAMP_ENTRY: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(acq_i) |=> clamp_q);                                          // R1
    AST_CLAMP_BOUNDED: assert property (@(posedge clk) disable iff (!rst_n)
        (clamp_q && acq_i && tick_any_i && cnt_q == CNT_LAST) |=> !clamp_q); // R1
    AST_TRACK_IGNORED: assert property (@(posedge clk) disable iff (!rst_n)
        (acq_i && $stable(acq_i) && $stable(clamp_q)) |-> $stable(mode_o));  // R5
endmodule

// File: rtl/pkt_peak_reg.sv
// Module: pkt_peak_reg
// One peak register with fraction bits; IS_POS picks positive or negative peak.
// Assumes: sample is signed SMP_W bits around zero bias; strobes one clock wide.
module pkt_peak_reg
    import pkt_pkg::*;
#(
    parameter int SMP_W       = 12,
    parameter int FRAC_W      = 11,
    parameter int AVG_UP_SH   = 4,
    parameter int AVG_LEAK_SH = 8,
    parameter int DECAY_SH    = 11,
    parameter bit IS_POS      = 1'b1
) (
    input  logic             clk,
    input  logic             rst_n,
    input  pkt_mode_e        mode_i,
    input  logic             tick_any_i,
    input  logic             tick_bit_i,
    input  logic [SMP_W-1:0] sample_i,
    output logic [SMP_W-1:0] peak_o
);
    localparam int RW    = SMP_W + FRAC_W;
    localparam int ACC_W = RW + 2;

    logic signed [RW-1:0]    pk_r;
    logic signed [ACC_W-1:0] acc, smp_ext, diff, tgt, cdiff, nxt;
    logic                    beyond;
    logic                    upd;

    // Widen register and sample onto a common fixed-point scale.
    always_comb begin
        acc     = {{2{pk_r[RW-1]}}, pk_r};
        smp_ext = {{(ACC_W-SMP_W){sample_i[SMP_W-1]}}, sample_i} <<< FRAC_W;
        diff    = smp_ext - acc;
        tgt     = smp_ext >>> 1;
        cdiff   = tgt - acc;
        beyond  = IS_POS ? (diff > 0) : (diff < 0);
    end

    // Next-value selection per mode and whether a strobe applies.
    always_comb begin
        nxt = acc;
        upd = 1'b0;
        unique case (mode_i)
            MD_CLAMP: begin
                upd = tick_any_i;
                nxt = acc + (cdiff >>> 1);
            end
            MD_FAST: begin
                upd = tick_any_i;
                nxt = beyond ? smp_ext : acc;
            end
            MD_AVG: begin
                upd = tick_bit_i;
                nxt = beyond ? acc + (diff >>> AVG_UP_SH)
                             : acc + (diff >>> AVG_LEAK_SH);
            end
            MD_HOLD: begin
                upd = tick_bit_i;
                nxt = acc - (acc >>> DECAY_SH);
            end
            default: begin
                upd = 1'b0;
                nxt = acc;
            end
        endcase
    end

    // Peak register update.
    always_ff @(posedge clk) begin
        if (!rst_n) pk_r <= '0;
        else if (upd) pk_r <= nxt[RW-1:0];
    end

    assign peak_o = pk_r[RW-1:FRAC_W];

    AST_FAST_CAPTURE: assert property (@(posedge clk) disable iff (!rst_n)
        (mode_i == MD_FAST && tick_any_i) |=>
        (IS_POS ? ($signed(peak_o) >= $signed($past(sample_i)))
                : ($signed(peak_o) <= $signed($past(sample_i)))));          // R2
    AST_AVG_DIRECTION: assert property (@(posedge clk) disable iff (!rst_n)
        (mode_i == MD_AVG && tick_bit_i && beyond) |=>
        (IS_POS ? (pk_r >= $past(pk_r)) : (pk_r <= $past(pk_r))));          // R3
    AST_HOLD_TOWARD_BIAS: assert property (@(posedge clk) disable iff (!rst_n)
        (mode_i == MD_HOLD && tick_bit_i) |=>
        (($past(pk_r) >= 0) ? (pk_r <= $past(pk_r) && pk_r >= 0)
                            : (pk_r >= $past(pk_r) && pk_r <= 0)));          // R4
endmodule

// File: rtl/pkt_slicer.sv
// Module: pkt_slicer
// Midpoint threshold from the two peaks and a bit-strobed data decision.
// Assumes: peaks are signed SMP_W-bit integers; positive sample above threshold means 0.
module pkt_slicer #(
    parameter int SMP_W = 12
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             tick_bit_i,
    input  logic [SMP_W-1:0] sample_i,
    input  logic [SMP_W-1:0] pos_i,
    input  logic [SMP_W-1:0] neg_i,
    output logic [SMP_W-1:0] thresh_o,
    output logic             data_o
);
    logic [SMP_W:0] sum;

    // Midpoint: sign-extended sum, arithmetic halving by dropping the LSB.
    always_comb begin
        sum      = {pos_i[SMP_W-1], pos_i} + {neg_i[SMP_W-1], neg_i};
        thresh_o = sum[SMP_W:1];
    end

    // Data decision registered on each bit strobe.
    always_ff @(posedge clk) begin
        if (!rst_n) data_o <= 1'b0;
        else if (tick_bit_i) data_o <= !($signed(sample_i) > $signed(thresh_o));
    end

    AST_THR_BETWEEN: assert property (@(posedge clk) disable iff (!rst_n)
        (($signed(pos_i) >= $signed(neg_i)) ->
            ($signed(thresh_o) <= $signed(pos_i) && $signed(thresh_o) >= $signed(neg_i))) &&
        (($signed(pos_i) <  $signed(neg_i)) ->
            ($signed(thresh_o) >= $signed(pos_i) && $signed(thresh_o) <= $signed(neg_i)))); // R6
    AST_DATA_ON_BIT: assert property (@(posedge clk) disable iff (!rst_n)
        !$past(tick_bit_i) |-> $stable(data_o));                                 // R7
endmodule

// File: rtl/peak_level_tracker.sv
// Module: peak_level_tracker (top)
// Tracks positive/negative peaks of a signed sample stream, forms a midpoint
// threshold and slices data. Assumes strobes come from clock recovery.
module peak_level_tracker
    import pkt_pkg::*;
#(
    parameter int SMP_W       = 12,
    parameter int FRAC_W      = 11,
    parameter int AVG_UP_SH   = 4,
    parameter int AVG_LEAK_SH = 8,
    parameter int DECAY_SH    = 11,
    parameter int CLAMP_TICKS = 2
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [SMP_W-1:0] sample_i,
    input  logic             half_tick_i,
    input  logic             bit_tick_i,
    input  logic             acq_i,
    input  logic             track_i,
    output logic [SMP_W-1:0] pos_peak_o,
    output logic [SMP_W-1:0] neg_peak_o,
    output logic [SMP_W-1:0] thresh_o,
    output logic             data_o,
    output logic [1:0]       mode_o
);
    localparam int NPK = 2;

    pkt_mode_e        mode;
    logic             tick_any;
    logic [SMP_W-1:0] peaks [NPK];

    assign tick_any = half_tick_i | bit_tick_i;

    pkt_mode_ctrl #(.CLAMP_TICKS(CLAMP_TICKS)) u_mode (
        .clk        (clk),
        .rst_n      (rst_n),
        .acq_i      (acq_i),
        .track_i    (track_i),
        .tick_any_i (tick_any),
        .mode_o     (mode)
    );

    // Index 0 is the positive peak, index 1 the negative peak.
    for (genvar g = 0; g < NPK; g++) begin : g_pk
        pkt_peak_reg #(
            .SMP_W       (SMP_W),
            .FRAC_W      (FRAC_W),
            .AVG_UP_SH   (AVG_UP_SH),
            .AVG_LEAK_SH (AVG_LEAK_SH),
            .DECAY_SH    (DECAY_SH),
            .IS_POS      (g == 0)
        ) u_pk (
            .clk        (clk),
            .rst_n      (rst_n),
            .mode_i     (mode),
            .tick_any_i (tick_any),
            .tick_bit_i (bit_tick_i),
            .sample_i   (sample_i),
            .peak_o     (peaks[g])
        );
    end

    assign pos_peak_o = peaks[0];
    assign neg_peak_o = peaks[1];
    assign mode_o     = mode;

    pkt_slicer #(.SMP_W(SMP_W)) u_slice (
        .clk        (clk),
        .rst_n      (rst_n),
        .tick_bit_i (bit_tick_i),
        .sample_i   (sample_i),
        .pos_i      (pos_peak_o),
        .neg_i      (neg_peak_o),
        .thresh_o   (thresh_o),
        .data_o     (data_o)
    );
endmodule

// File: tb/sim_peak_level_tracker.sv
// Directed bench for peak_level_tracker with a fractional reference model.
module sim_peak_level_tracker;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [11:0] sample_i = '0;
    logic        half_tick_i = 1'b0, bit_tick_i = 1'b0;
    logic        acq_i = 1'b0, track_i = 1'b0;
    logic [11:0] pos_peak_o, neg_peak_o, thresh_o;
    logic        data_o;
    logic [1:0]  mode_o;

    int n_run = 0, n_fail = 0;

    // Model state
    longint m_pos = 0, m_neg = 0;
    bit     m_clamp = 0, m_data = 0, b_acq = 0, b_track = 0;
    int     m_cnt = 0;

    always #4 clk = ~clk;

    peak_level_tracker u0 (
        .clk(clk), .rst_n(rst_n), .sample_i(sample_i),
        .half_tick_i(half_tick_i), .bit_tick_i(bit_tick_i),
        .acq_i(acq_i), .track_i(track_i),
        .pos_peak_o(pos_peak_o), .neg_peak_o(neg_peak_o),
        .thresh_o(thresh_o), .data_o(data_o), .mode_o(mode_o)
    );

    task automatic chk(string req, longint act, longint exp);
        n_run++;
        if (act != exp) begin
            n_fail++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    function automatic int m_mode();
        if (m_clamp && b_acq) return 3;
        if (b_acq)            return 2;
        if (b_track)          return 1;
        return 0;
    endfunction

    function automatic longint m_int(longint r);
        return r >>> 11;
    endfunction

    function automatic longint m_thr();
        return (m_int(m_pos) + m_int(m_neg)) >>> 1;
    endfunction

    function automatic longint m_next(longint r, longint s, bit is_pos, int md, bit isbit);
        longint se, d;
        bit beyond;
        se = s <<< 11;
        d  = se - r;
        beyond = is_pos ? (d > 0) : (d < 0);
        case (md)
            3: return r + (((se >>> 1) - r) >>> 1);
            2: return beyond ? se : r;
            1: return isbit ? (beyond ? r + (d >>> 4) : r + (d >>> 8)) : r;
            default: return isbit ? r - (r >>> 11) : r;
        endcase
    endfunction

    // One strobe with the given sample; updates the model alongside.
    task automatic step(bit isbit, int s);
        int md;
        @(negedge clk);
        sample_i = 12'(s);
        if (isbit) bit_tick_i = 1'b1; else half_tick_i = 1'b1;
        md = m_mode();
        if (isbit) m_data = !(longint'(s) > m_thr());
        m_pos = m_next(m_pos, s, 1'b1, md, isbit);
        m_neg = m_next(m_neg, s, 1'b0, md, isbit);
        if (md == 3) begin
            m_cnt++;
            if (m_cnt == 2) m_clamp = 0;
        end
        @(negedge clk);
        bit_tick_i = 1'b0; half_tick_i = 1'b0;
    endtask

    task automatic bit_period(int s);
        step(1'b0, s);
        step(1'b1, s);
    endtask

    task automatic set_ctrl(bit a, bit t);
        @(negedge clk);
        if (a && !b_acq) begin m_clamp = 1; m_cnt = 0; end
        if (!a) m_clamp = 0;
        acq_i = a; track_i = t; b_acq = a; b_track = t;
        @(negedge clk);
    endtask

    task automatic chk_all(string req);
        chk({req, " pos"},  longint'($signed(pos_peak_o)), m_int(m_pos));
        chk({req, " neg"},  longint'($signed(neg_peak_o)), m_int(m_neg));
        chk({req, " R6 thr"}, longint'($signed(thresh_o)), m_thr());
        chk({req, " R7 data"}, longint'(data_o), longint'(m_data));
        chk({req, " R8 mode"}, longint'(mode_o), longint'(m_mode()));
    endtask

    // R9: reset state
    task automatic t_reset();
        @(negedge clk);
        chk("R9 pos", longint'($signed(pos_peak_o)), 0);
        chk("R9 neg", longint'($signed(neg_peak_o)), 0);
        chk("R9 thr", longint'($signed(thresh_o)), 0);
        chk("R9 data", longint'(data_o), 0);
        chk("R8 mode hold", longint'(mode_o), 0);
    endtask

    // R1: clamp toward half the input over two strobes
    task automatic t_clamp();
        sample_i = 12'd1000;
        set_ctrl(1'b1, 1'b0);
        chk("R1 mode clamp", longint'(mode_o), 3);
        step(1'b0, 1000);
        chk("R1 still clamp", longint'(mode_o), 3);
        chk("R1 step1 pos", longint'($signed(pos_peak_o)), 250);
        step(1'b1, 1000);
        chk("R1 step2 pos", longint'($signed(pos_peak_o)), 375);
        chk("R1 step2 neg", longint'($signed(neg_peak_o)), 375);
        chk("R1 ends to fast", longint'(mode_o), 2);
        chk_all("R1");
    endtask

    // R2: fast peak capture
    task automatic t_fast();
        bit_period(800);
        bit_period(-600);
        bit_period(200);
        chk("R2 pos", longint'($signed(pos_peak_o)), 800);
        chk("R2 neg", longint'($signed(neg_peak_o)), -600);
        chk("R6 thr mid", longint'($signed(thresh_o)), 100);
        chk_all("R2");
    endtask

    // R5: track input ignored under acquire
    task automatic t_track_ignored();
        set_ctrl(1'b1, 1'b1);
        chk("R5 mode fast t=1", longint'(mode_o), 2);
        bit_period(900);
        chk("R5 fast still captures", longint'($signed(pos_peak_o)), 900);
        set_ctrl(1'b1, 1'b0);
        chk("R5 mode fast t=0", longint'(mode_o), 2);
        bit_period(-700);
        chk("R5 neg capture", longint'($signed(neg_peak_o)), -700);
        chk_all("R5");
    endtask

    // R7: slicer incl. equality
    task automatic t_slicer();
        // thr now (900 + -700)/2 = 100
        chk("R6 thr", longint'($signed(thresh_o)), 100);
        bit_period(100);
        chk("R7 equal gives 1", longint'(data_o), 1);
        bit_period(101);
        chk("R7 above gives 0", longint'(data_o), 0);
        bit_period(99);
        chk("R7 below gives 1", longint'(data_o), 1);
        step(1'b0, 500);
        chk("R7 held on half strobe", longint'(data_o), 1);
        step(1'b1, 500);
        chk_all("R7");
    endtask

    // R3: averaging
    task automatic t_avg();
        longint p0;
        set_ctrl(1'b0, 1'b1);
        chk("R8 mode avg", longint'(mode_o), 1);
        p0 = m_pos;
        step(1'b0, 2000);
        chk("R3 half strobe no change", longint'($signed(pos_peak_o)), m_int(p0));
        step(1'b1, 2000);
        chk_all("R3 up");
        for (int i = 0; i < 20; i++) bit_period(2000);
        chk_all("R3 up run");
        for (int i = 0; i < 30; i++) bit_period(0);
        chk_all("R3 leak");
        for (int i = 0; i < 10; i++) bit_period(-1500);
        chk_all("R3 neg");
    endtask

    // R4: hold decay, samples ignored
    task automatic t_hold();
        longint p0;
        set_ctrl(1'b0, 1'b0);
        chk("R8 mode hold", longint'(mode_o), 0);
        p0 = m_int(m_pos);
        for (int i = 0; i < 400; i++) bit_period(2047);
        chk_all("R4 decay");
        n_run++;
        if (!($signed(pos_peak_o) < p0)) begin
            n_fail++;
            $display("FAIL R4 pos not decayed actual=%0d expected<%0d", $signed(pos_peak_o), p0);
        end
        for (int i = 0; i < 100; i++) bit_period(-2048);
        chk_all("R4 neg ignored");
    endtask

    // R1: re-clamp from negative input, and cancel when acquire drops
    task automatic t_reclamp();
        set_ctrl(1'b1, 1'b0);
        chk("R1 reclamp mode", longint'(mode_o), 3);
        step(1'b0, -1200);
        chk_all("R1 neg step1");
        set_ctrl(1'b0, 1'b1);
        chk("R1 cancel to avg", longint'(mode_o), 1);
        bit_period(-1200);
        chk_all("R1 after cancel");
        set_ctrl(1'b1, 1'b1);
        step(1'b1, -1200);
        step(1'b0, -1200);
        chk("R1 fast after two", longint'(mode_o), 2);
        chk_all("R1 neg clamp");
    endtask

    initial begin
        #(8 * 150000);
        n_fail++;
        $display("FAIL watchdog expired actual=running expected=done");
        $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
        $finish;
    end

    initial begin
        repeat (4) @(negedge clk);
        rst_n = 1'b1;
        t_reset();
        t_clamp();
        t_fast();
        t_track_ignored();
        t_slicer();
        t_avg();
        t_hold();
        t_reclamp();
        $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
        $finish;
    end
endmodule